// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block runs an external dual-slope integrating converter. It drives three analog switch enables and measures the de-integration time with a 16-bit counter. Each conversion has three phases in a fixed order. First the auto-zero phase stores the integrator offset. Next the unknown input is integrated for a fixed period. Last the reference is integrated until an external comparator reports a zero crossing. The counter value captured at that crossing is proportional to the input amplitude.

The length of each of the first two phases is set by a reload value. The counter is loaded with that value and the phase ends when the counter overflows. For the input phase this reload should give a whole number of mains cycles. The counter wraps to zero at the end of the input phase and keeps counting through the reference phase. The comparator passes through two synchronizer flops, and one more register stage captures the result. Because of this pipeline, the result always carries a fixed offset of 3 counts, which the host subtracts. A conversion can also be held until a mains-line sync pulse arrives.

States: `ST_IDLE` (no switch on), `ST_ARM` (waiting for the mains pulse), `ST_AZ` (auto-zero switch on), `ST_INT` (input switch on), `ST_REF` (reference switch on). Transitions:
- start (IDLE→AZ, or IDLE→ARM in sync mode)
- pulse (ARM→AZ)
- az_wrap (AZ→INT)
- int_wrap (INT→REF)
- trip (REF→IDLE, result captured)
- abort (REF→IDLE, overrange)
- rst (any state→IDLE)

Top module: `dslope_adc_seq`

## Requirements
- R1: During and after reset, `sw_az`, `sw_in`, `sw_ref`, `busy`, `done` and `overrange` are 0 and `result` is 0.
- R2: With `sync_mode` = 0, a `start_req` sampled high in idle makes `busy` and `sw_az` high in the next cycle, with the other two switches low.
- R3: `sw_az` stays high for exactly 65536 − `az_reload` cycles. It is then followed directly by `sw_in`.
- R4: `sw_in` stays high for exactly 65536 − `int_reload` cycles. It is then followed directly by `sw_ref`, and the counter enters the reference phase at 0.
- R5: At most one switch enable is high in any cycle.
- R6: The first edge at which `cmp_in` is sampled high is counted as edge m+1, where edge 0 is the edge that enters the reference phase. Provided `cmp_in` was low at the two edges before edge m+1, `done` pulses for one cycle in the third cycle after edge m+1. In that cycle `result` = m+3, all switches are low and `busy` is low.
- R7: A comparator that is already high when the reference phase begins does not end it. Only a low-to-high transition of the synchronized comparator ends the phase.
- R8: If no crossing occurs within 65536 reference-phase cycles, the conversion aborts. `done` pulses with `overrange` = 1, all switches off, and `result` unchanged.
- R9: With `sync_mode` = 1, an accepted start raises `busy` but turns on no switch. `sw_az` rises in the cycle after `mains_pulse` is sampled high.
- R10: A `start_req` that arrives while busy is ignored. The phase timing of the conversion in progress is unchanged.
- R11: `result` holds its value between completions. `overrange` stays set until the next accepted start clears it.
- R12: A synchronous `rst` in mid-conversion returns the block to idle in the next cycle, with all outputs at their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Conversion request, sampled in idle |
| sync_mode | input | 1 | 1: wait for mains pulse before auto-zero |
| mains_pulse | input | 1 | Mains-line sync pulse (synchronous) |
| az_reload | input | 16 | Counter load value for auto-zero phase |
| int_reload | input | 16 | Counter load value for input phase |
| cmp_in | input | 1 | Asynchronous comparator output |
| sw_az | output | 1 | Auto-zero switch enable |
| sw_in | output | 1 | Input switch enable |
| sw_ref | output | 1 | Reference switch enable |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | De-integration count, offset by +3 |
| overrange | output | 1 | Last conversion aborted without a crossing |

## Verification
The bench counts the exact phase lengths from reload values near the overflow point. A counter that is off by one, or a hand-off that reloads the counter, would show up as a wrong length. It places the comparator edge at several offsets, including the very first reference cycle. A pipeline of the wrong depth would miss the m+3 result. It holds the comparator high across the input-to-reference hand-off, where a level detector would finish at once with a tiny count. It also runs a conversion that never trips. Without the abort, the switches would stay on forever, or the previous result would be overwritten.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARM  = 3'd1,
        ST_AZ   = 3'd2,
        ST_INT  = 3'd3,
        ST_REF  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (run)  cnt <= cnt + 1'b1;
    end

    // Overflow event: the increment in this cycle takes the count past its top.
    assign wrap = run && (cnt == ALL_ONES);

    // R4: the counter advances by one (wrapping) whenever it runs without a load
    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !load) |=> (cnt == W'($past(cnt) + 1'b1)));

    // R3: a load puts the reload value into the counter
    assert_load_value_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
    import dsadc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_req,
    input  logic         sync_mode,
    input  logic         mains_pulse,
    input  logic [W-1:0] az_reload,
    input  logic [W-1:0] int_reload,
    input  logic         cmp_s,
    input  logic [W-1:0] cnt,
    input  logic         wrap,
    output logic         load,
    output logic [W-1:0] load_val,
    output logic         run,
    output logic         sw_az,
    output logic         sw_in,
    output logic         sw_ref,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result,
    output logic         overrange
);
    seq_state_t state_q, state_d;
    logic       cmp_prev_q;
    logic       trip;
    logic       accept;

    assign accept = (state_q == ST_IDLE) && start_req;
    assign trip   = (state_q == ST_REF) && cmp_s && !cmp_prev_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req)   state_d = sync_mode ? ST_ARM : ST_AZ;
            ST_ARM:  if (mains_pulse) state_d = ST_AZ;
            ST_AZ:   if (wrap)        state_d = ST_INT;
            ST_INT:  if (wrap)        state_d = ST_REF;
            ST_REF:  if (trip || wrap) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Combinational outputs decoded from the state register
    always_comb begin
        sw_az    = 1'b0;
        sw_in    = 1'b0;
        sw_ref   = 1'b0;
        busy     = 1'b1;
        run      = 1'b0;
        load     = 1'b0;
        load_val = az_reload;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start_req && !sync_mode;
            end
            ST_ARM: begin
                load = mains_pulse;
            end
            ST_AZ: begin
                sw_az    = 1'b1;
                run      = 1'b1;
                load     = wrap;
                load_val = int_reload;
            end
            ST_INT: begin
                sw_in = 1'b1;
                run   = 1'b1;
            end
            ST_REF: begin
                sw_ref = 1'b1;
                run    = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // Registered completion: edge history, result, pulse, overrange flag
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_prev_q <= 1'b0;
            result     <= '0;
            done       <= 1'b0;
            overrange  <= 1'b0;
        end else begin
            cmp_prev_q <= cmp_s;
            done       <= 1'b0;
            if (accept) overrange <= 1'b0;
            if (trip) begin
                result <= cnt + 1'b1;
                done   <= 1'b1;
            end else if (state_q == ST_REF && wrap) begin
                overrange <= 1'b1;
                done      <= 1'b1;
            end
        end
    end

    // R5: never more than one switch enable at a time
    assert_onehot_sw_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sw_az, sw_in, sw_ref}));

    // R6: done is a single-cycle pulse with every switch released
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!sw_az && !sw_in && !sw_ref && !busy));

    // R3 / R4: phases follow each other in fixed order
    assert_az_before_in_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_in) |-> $past(sw_az));
    assert_in_before_ref_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_ref) |-> $past(sw_in));

    // R11: result only moves at a completion
    assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(result));
endmodule

// File: rtl/dslope_adc_seq.sv
module dslope_adc_seq #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             sync_mode,
    input  logic             mains_pulse,
    input  logic [CNT_W-1:0] az_reload,
    input  logic [CNT_W-1:0] int_reload,
    input  logic             cmp_in,
    output logic             sw_az,
    output logic             sw_in,
    output logic             sw_ref,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] result,
    output logic             overrange
);
    logic             cmp_s;
    logic             ctr_load;
    logic             ctr_run;
    logic             ctr_wrap;
    logic [CNT_W-1:0] ctr_load_val;
    logic [CNT_W-1:0] ctr_cnt;

    dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmp_in),
        .q   (cmp_s)
    );

    dsadc_counter #(.W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_load),
        .load_val (ctr_load_val),
        .run      (ctr_run),
        .cnt      (ctr_cnt),
        .wrap     (ctr_wrap)
    );

    dsadc_fsm #(.W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .sync_mode   (sync_mode),
        .mains_pulse (mains_pulse),
        .az_reload   (az_reload),
        .int_reload  (int_reload),
        .cmp_s       (cmp_s),
        .cnt         (ctr_cnt),
        .wrap        (ctr_wrap),
        .load        (ctr_load),
        .load_val    (ctr_load_val),
        .run         (ctr_run),
        .sw_az       (sw_az),
        .sw_in       (sw_in),
        .sw_ref      (sw_ref),
        .busy        (busy),
        .done        (done),
        .result      (result),
        .overrange   (overrange)
    );
endmodule

// File: tb/dslope_adc_seq_tb.sv
module dslope_adc_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_req = 1'b0;
    logic        sync_mode = 1'b0;
    logic        mains_pulse = 1'b0;
    logic [15:0] az_reload = 16'hFFF0;
    logic [15:0] int_reload = 16'hFFE0;
    logic        cmp_in = 1'b0;
    logic        sw_az, sw_in, sw_ref, busy, done, overrange;
    logic [15:0] result;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dslope_adc_seq dut_i (
        .clk(clk), .rst(rst), .start_req(start_req), .sync_mode(sync_mode),
        .mains_pulse(mains_pulse), .az_reload(az_reload), .int_reload(int_reload),
        .cmp_in(cmp_in), .sw_az(sw_az), .sw_in(sw_in), .sw_ref(sw_ref),
        .busy(busy), .done(done), .result(result), .overrange(overrange)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R5: continuous one-hot monitor on the switch enables
    int onehot_bad = 0;
    always @(negedge clk) begin
        if (!rst && (int'(sw_az) + int'(sw_in) + int'(sw_ref)) > 1) onehot_bad++;
    end

    task automatic do_start();
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
    endtask

    // Drives a conversion up to the first sampled cycle of the reference phase
    task automatic go_to_ref();
        int n;
        do_start();
        n = 0;
        while (!sw_ref && n < 140000) begin tick(); n++; end
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 70000) begin tick(); n++; end
    endtask

    task automatic t_reset();
        tick();
        check(!sw_az && !sw_in && !sw_ref, "R1", "switches in reset", {sw_az, sw_in, sw_ref}, 0);
        check(!busy && !done && !overrange && result == 0, "R1", "status in reset", result, 0);
        rst = 1'b0;
        tick();
        check(!busy && !sw_az, "R1", "idle after reset", busy, 0);
    endtask

    task automatic t_basic(input logic [15:0] az, input logic [15:0] inr, input int m,
                           input bit chk_ovr_clear);
        int n;
        az_reload = az; int_reload = inr; cmp_in = 1'b0; sync_mode = 1'b0;
        do_start();
        check(busy && sw_az && !sw_in && !sw_ref, "R2", "auto-zero after start",
              {busy, sw_az, sw_in, sw_ref}, 4'b1100);
        if (chk_ovr_clear) check(!overrange, "R11", "overrange cleared by start", overrange, 0);
        n = 0;
        while (sw_az && n < 70000) begin n++; tick(); end
        check(n == 65536 - int'(az), "R3", "auto-zero length", n, 65536 - int'(az));
        check(sw_in, "R3", "input switch follows", sw_in, 1);
        n = 0;
        while (sw_in && n < 70000) begin n++; tick(); end
        check(n == 65536 - int'(inr), "R4", "input length", n, 65536 - int'(inr));
        check(sw_ref, "R4", "reference switch follows", sw_ref, 1);
        repeat (m) tick();
        cmp_in = 1'b1;
        wait_done(n);
        check(n == 3, "R6", "done latency", n, 3);
        check(result == 16'(m + 3), "R6", "result count", result, m + 3);
        check(!sw_az && !sw_in && !sw_ref && !busy, "R6", "released at done",
              {busy, sw_az, sw_in, sw_ref}, 0);
        tick();
        check(!done, "R6", "done single cycle", done, 0);
        cmp_in = 1'b0;
    endtask

    task automatic t_cmp_high(); // R7
        int n;
        az_reload = 16'hFFF8; int_reload = 16'hFFF0; cmp_in = 1'b1;
        go_to_ref();
        repeat (6) tick();
        check(sw_ref && !done, "R7", "held-high comparator ignored", sw_ref, 1);
        cmp_in = 1'b0;
        repeat (4) tick();
        cmp_in = 1'b1;
        wait_done(n);
        check(result == 16'd13, "R7", "result after real crossing", result, 13);
        cmp_in = 1'b0;
        tick();
    endtask

    task automatic t_overrange(); // R8
        int n;
        logic [15:0] prev;
        prev = result;
        az_reload = 16'hFFFC; int_reload = 16'hFFFC; cmp_in = 1'b0;
        go_to_ref();
        wait_done(n);
        check(n == 65536, "R8", "abort after full wrap", n, 65536);
        check(overrange, "R8", "overrange set", overrange, 1);
        check(result == prev, "R8", "result kept on abort", result, prev);
        check(!sw_az && !sw_in && !sw_ref && !busy, "R8", "switches released", sw_ref, 0);
        repeat (5) tick();
        check(overrange, "R11", "overrange holds in idle", overrange, 1);
    endtask

    task automatic t_hold(); // R11
        logic [15:0] r;
        r = result;
        repeat (20) tick();
        check(result == r && !done, "R11", "result held between conversions", result, r);
    endtask

    task automatic t_sync(); // R9
        int n;
        az_reload = 16'hFFF0; int_reload = 16'hFFF0; sync_mode = 1'b1; cmp_in = 1'b0;
        do_start();
        check(busy && !sw_az && !sw_in && !sw_ref, "R9", "armed without switches", {busy, sw_az}, 2);
        repeat (5) tick();
        check(busy && !sw_az, "R9", "still waiting for mains", sw_az, 0);
        mains_pulse = 1'b1;
        tick();
        mains_pulse = 1'b0;
        sync_mode = 1'b0;
        check(sw_az, "R9", "auto-zero after mains pulse", sw_az, 1);
        n = 0;
        while (sw_az && n < 70000) begin n++; tick(); end
        check(n == 16, "R9", "auto-zero length after pulse", n, 16);
        while (!sw_ref && n < 140000) begin n++; tick(); end
        cmp_in = 1'b1; // m = 0 boundary
        wait_done(n);
        check(result == 16'd3, "R6", "crossing in first reference cycle", result, 3);
        cmp_in = 1'b0;
        tick();
    endtask

    task automatic t_busy_reset(); // R10, R12
        int n;
        az_reload = 16'hFFE0; int_reload = 16'hFFC0; cmp_in = 1'b0;
        do_start();
        n = 0;
        while (sw_az && n < 70000) begin
            if (n == 5) start_req = 1'b1;
            if (n == 8) start_req = 1'b0;
            n++; tick();
        end
        check(n == 32, "R10", "start while busy ignored", n, 32);
        repeat (10) tick();
        check(sw_in, "R10", "still in input phase", sw_in, 1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check(!busy && !sw_az && !sw_in && !sw_ref && !done, "R12", "reset mid-conversion",
              {busy, sw_in}, 0);
        check(result == 0 && !overrange, "R12", "result cleared by reset", result, 0);
        tick();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic(16'hFFF0, 16'hFFE0, 7, 1'b0);
        t_basic(16'hFFFF, 16'hFFFE, 20, 1'b0);
        t_cmp_high();
        t_overrange();
        t_basic(16'hFFF4, 16'hFFF8, 2, 1'b1);
        t_hold();
        t_sync();
        t_busy_reset();
        check(onehot_bad == 0, "R5", "one switch at a time", onehot_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule